// File: doc/BRIEF.md
# Carry-Linked Power-of-Two Clock Divider

This block produces a single-cycle enable pulse once every 2^E cycles of its input clock. E is a 4-bit divide exponent. Beside E sits an 8-bit stage word. A loop-filter command port can raise or lower the stage word by a fine step (weight 1) or a coarse step (weight 32). The command port never writes the exponent. The exponent moves up by one when an addition overflows the stage word, and down by one when a subtraction underflows it. The exponent and the stage word therefore behave as one extended register: the exponent is the high part and counts in powers of two.

The usable exponent range is 0 to 9, so the divide ratio runs from 1 to 512. An exponent code above nine divides exactly as nine does. At both ends of the range the stage word saturates rather than wrapping. A new exponent is picked up only when the running output period ends, so a period is never cut short.

The block leaves out the decision logic that chooses the adjust commands and the frequency comparison that drives that logic. Both belong to the surrounding loop.

Top module: `pow2_clk_div`

## Requirements
- R1: After reset is released, the exponent is 0 and the stage word is 0x00, and `div_tick` is high in every input cycle.
- R2: With a settled exponent E (0 to 9), `div_tick` is a one-cycle pulse that repeats every 2^E input cycles. E = 9 gives a period of 512.
- R3: A fine command (`adj_valid`=1, `adj_coarse`=0) changes the stage word by +1 when `adj_up`=1 and by −1 when `adj_up`=0. The result is visible one clock later. The exponent does not change unless the arithmetic overflows or underflows.
- R4: A coarse command (`adj_valid`=1, `adj_coarse`=1) changes the stage word by +32 when `adj_up`=1 and by −32 when `adj_up`=0. This is bit 5 of the stage word.
- R5: An addition whose 9-bit result exceeds 255, applied while the exponent is below 9, leaves the stage word at the result modulo 256 and raises the exponent by one.
- R6: A subtraction whose result is below zero, applied while the exponent is above 0, leaves the stage word at the result modulo 256 and lowers the exponent by one.
- R7: An addition that overflows while the exponent is 9 sets the stage word to 0xFF and leaves the exponent at 9. The exponent never exceeds 9.
- R8: A subtraction that underflows while the exponent is 0 sets the stage word to 0x00 and leaves the exponent at 0.
- R9: After the exponent changes, the output period that is running finishes at its old length. Every later period uses the new exponent.
- R10: While `adj_valid` is low, the exponent and the stage word hold, whatever `adj_up` and `adj_coarse` carry.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adj_valid | input | 1 | Apply one adjust command this cycle |
| adj_up | input | 1 | 1 = add the step, 0 = subtract the step |
| adj_coarse | input | 1 | 1 = coarse step (32), 0 = fine step (1) |
| div_tick | output | 1 | One-cycle enable at the divided rate |
| exp_o | output | 4 | Current divide exponent |
| stage_o | output | 8 | Current stage word |

## Verification
Fine and coarse steps are applied in both directions from stage values chosen so that the step stays inside the word. Other starting values make the step overflow or underflow. Together these separate plain stepping, carry into the exponent, and saturation at exponent 9 and exponent 0. Long runs of coarse additions walk the exponent from 0 to 9, and the pulse spacing is measured at every level, which shows that the divide ratio doubles per step. An exponent change is issued in the same cycle as an output pulse, once upward and once downward. The two following gaps are measured, which separates a change held to the period boundary from one applied at once. An idle period with the direction and size inputs toggling shows that they are ignored when no command is valid.

// File: rtl/pow2_clk_div_pkg.sv
package pow2_clk_div_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } adj_dir_e;

    // Map an exponent code onto the usable range: codes above the top act as the top.
    function automatic int unsigned clamp_code(input int unsigned code, input int unsigned top);
        return (code > top) ? top : code;
    endfunction

endpackage

// File: rtl/stage_adjuster.sv
module stage_adjuster
    import pow2_clk_div_pkg::*;
#(
    parameter int STAGE_W    = 8,
    parameter int EXP_W      = 4,
    parameter int EXP_MAX    = 9,
    parameter int COARSE_BIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adj_valid,
    input  logic               adj_up,
    input  logic               adj_coarse,
    output logic [STAGE_W-1:0] stage_q_o,
    output logic [EXP_W-1:0]   exp_q_o
);

    localparam int SUM_W = STAGE_W + 1;

    typedef struct packed {
        logic [EXP_W-1:0]   expo;
        logic [STAGE_W-1:0] stage;
    } adj_state_t;

    adj_state_t st_d, st_q;

    logic [SUM_W-1:0] step_w;
    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] diff_w;
    logic [EXP_W-1:0] exp_eff;
    logic             exp_at_top;
    logic             exp_at_bot;
    adj_dir_e         dir;

    always_comb begin
        dir        = adj_dir_e'(adj_up);
        step_w     = adj_coarse ? (SUM_W'(1) << COARSE_BIT) : SUM_W'(1);
        sum_w      = {1'b0, st_q.stage} + step_w;
        diff_w     = {1'b0, st_q.stage} - step_w;
        exp_eff    = EXP_W'(clamp_code(int'(st_q.expo), EXP_MAX));
        exp_at_top = (exp_eff == EXP_W'(EXP_MAX));
        exp_at_bot = (exp_eff == '0);

        st_d = st_q;
        if (adj_valid) begin
            if (dir == DIR_UP) begin
                if (!sum_w[STAGE_W]) begin
                    st_d.stage = sum_w[STAGE_W-1:0];
                end else if (exp_at_top) begin
                    st_d.stage = '1;
                    st_d.expo  = exp_eff;
                end else begin
                    st_d.stage = sum_w[STAGE_W-1:0];
                    st_d.expo  = exp_eff + EXP_W'(1);
                end
            end else begin
                if (!diff_w[STAGE_W]) begin
                    st_d.stage = diff_w[STAGE_W-1:0];
                end else if (exp_at_bot) begin
                    st_d.stage = '0;
                    st_d.expo  = '0;
                end else begin
                    st_d.stage = diff_w[STAGE_W-1:0];
                    st_d.expo  = exp_eff - EXP_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_q_o = st_q.stage;
    assign exp_q_o   = st_q.expo;

endmodule

// File: rtl/period_counter.sv
module period_counter
    import pow2_clk_div_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9,
    parameter int CNT_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_req,
    output logic             tick_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [EXP_W-1:0] act;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;

    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    always_comb begin
        // Terminal count of the running period: 2^act - 1.
        last_cnt = ~({CNT_W{1'b1}} << cs_q.act);
        wrap     = (cs_q.cnt == last_cnt);

        cs_d = cs_q;
        if (wrap) begin
            cs_d.cnt = '0;
            // The requested exponent is sampled only at a period boundary.
            cs_d.act = EXP_W'(clamp_code(int'(exp_req), EXP_MAX));
        end else begin
            cs_d.cnt = cs_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign tick_o = wrap;

endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div #(
    parameter int STAGE_W    = 8,
    parameter int EXP_W      = 4,
    parameter int EXP_MAX    = 9,
    parameter int COARSE_BIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adj_valid,
    input  logic               adj_up,
    input  logic               adj_coarse,
    output logic               div_tick,
    output logic [EXP_W-1:0]   exp_o,
    output logic [STAGE_W-1:0] stage_o
);

    localparam int CNT_W = (EXP_MAX > 0) ? EXP_MAX : 1;

    logic [STAGE_W-1:0] stage_w;
    logic [EXP_W-1:0]   exp_w;

    stage_adjuster #(
        .STAGE_W   (STAGE_W),
        .EXP_W     (EXP_W),
        .EXP_MAX   (EXP_MAX),
        .COARSE_BIT(COARSE_BIT)
    ) u_adj (
        .clk       (clk),
        .rst_n     (rst_n),
        .adj_valid (adj_valid),
        .adj_up    (adj_up),
        .adj_coarse(adj_coarse),
        .stage_q_o (stage_w),
        .exp_q_o   (exp_w)
    );

    period_counter #(
        .EXP_W  (EXP_W),
        .EXP_MAX(EXP_MAX),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_req(exp_w),
        .tick_o (div_tick)
    );

    assign exp_o   = exp_w;
    assign stage_o = stage_w;

endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk #(
    parameter int STAGE_W = 8,
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adj_valid,
    input logic               adj_up,
    input logic               adj_coarse,
    input logic               div_tick,
    input logic [EXP_W-1:0]   exp_o,
    input logic [STAGE_W-1:0] stage_o
);

    // R1: the first active cycle after reset shows a cleared state and a pulse.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (exp_o == '0 && stage_o == '0 && div_tick));

    // R10: no valid command, no change.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_valid |=> ($stable(exp_o) && $stable(stage_o)));

    // R7: the exponent stays inside its usable range.
    p_exp_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_o <= EXP_W'(EXP_MAX));

    // R5 / R6: one command moves the exponent by at most one code.
    p_exp_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adj_valid |=> (exp_o == $past(exp_o) ||
                       exp_o == $past(exp_o) + EXP_W'(1) ||
                       exp_o == $past(exp_o) - EXP_W'(1)));

    // R3: a fine upward step without overflow adds one and leaves the exponent alone.
    p_fine_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_valid && adj_up && !adj_coarse && stage_o != '1) |=>
        (stage_o == $past(stage_o) + STAGE_W'(1) && $stable(exp_o)));

    // R8: underflow at the bottom exponent pins the stage word at zero.
    p_floor_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_valid && !adj_up && !adj_coarse && exp_o == '0 && stage_o == '0) |=>
        (exp_o == '0 && stage_o == '0));

endmodule

bind pow2_clk_div pow2_clk_div_chk #(
    .STAGE_W(STAGE_W),
    .EXP_W  (EXP_W),
    .EXP_MAX(EXP_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adj_valid (adj_valid),
    .adj_up    (adj_up),
    .adj_coarse(adj_coarse),
    .div_tick  (div_tick),
    .exp_o     (exp_o),
    .stage_o   (stage_o)
);

// File: tb/tb_pow2_clk_div.sv
`timescale 1ns/1ps
module tb_pow2_clk_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adj_valid = 1'b0;
    logic       adj_up = 1'b0;
    logic       adj_coarse = 1'b0;
    logic       div_tick;
    logic [3:0] exp_o;
    logic [7:0] stage_o;

    int checks = 0;
    int errors = 0;
    int exp_m = 0;
    int stage_m = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pow2_clk_div dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .adj_valid (adj_valid),
        .adj_up    (adj_up),
        .adj_coarse(adj_coarse),
        .div_tick  (div_tick),
        .exp_o     (exp_o),
        .stage_o   (stage_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One command; the model follows the requirements. Called at a negedge, returns at a negedge.
    task automatic adj(input bit up, input bit coarse, input string req);
        int step;
        step = coarse ? 32 : 1;
        adj_valid  = 1'b1;
        adj_up     = up;
        adj_coarse = coarse;
        if (up) begin
            if (stage_m + step <= 255) stage_m = stage_m + step;
            else if (exp_m >= 9) stage_m = 255;
            else begin stage_m = stage_m + step - 256; exp_m++; end
        end else begin
            if (stage_m >= step) stage_m = stage_m - step;
            else if (exp_m == 0) stage_m = 0;
            else begin stage_m = stage_m + 256 - step; exp_m--; end
        end
        @(negedge clk);
        adj_valid = 1'b0;
        check(stage_o == 8'(stage_m), req, "stage word", int'(stage_o), stage_m);
        check(exp_o == 4'(exp_m), req, "exponent", int'(exp_o), exp_m);
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        while (!div_tick) @(negedge clk);
    endtask

    task automatic measure_gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!div_tick);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(exp_o == 4'd0, "R1", "exponent after reset", int'(exp_o), 0);
        check(stage_o == 8'd0, "R1", "stage after reset", int'(stage_o), 0);
        for (int i = 0; i < 4; i++) begin
            check(div_tick == 1'b1, "R1", "tick every cycle", int'(div_tick), 1);
            @(negedge clk);
        end
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            adj_up     = i[0];
            adj_coarse = i[1];
            @(negedge clk);
            check(stage_o == 8'(stage_m), "R10", "stage while idle", int'(stage_o), stage_m);
            check(exp_o == 4'(exp_m), "R10", "exponent while idle", int'(exp_o), exp_m);
        end
    endtask

    task automatic t_fine();
        adj(1'b1, 1'b0, "R3");
        adj(1'b1, 1'b0, "R3");
        adj(1'b1, 1'b0, "R3");
        adj(1'b0, 1'b0, "R3");
        check(stage_o == 8'd2, "R3", "stage after +3-1", int'(stage_o), 2);
    endtask

    task automatic t_coarse();
        adj(1'b1, 1'b0 | 1'b1, "R4");
        check(stage_o == 8'd34, "R4", "stage after +32", int'(stage_o), 34);
        adj(1'b0, 1'b1, "R4");
        check(stage_o == 8'd2, "R4", "stage after -32", int'(stage_o), 2);
    endtask

    task automatic t_carry();
        for (int i = 0; i < 7; i++) adj(1'b1, 1'b1, "R4");
        adj(1'b1, 1'b1, "R5");
        check(exp_o == 4'd1 && stage_o == 8'd2, "R5", "carry into exponent",
              int'({exp_o, stage_o}), (1 << 8) | 2);
    endtask

    task automatic t_borrow();
        adj(1'b0, 1'b1, "R6");
        check(exp_o == 4'd0 && stage_o == 8'd226, "R6", "borrow from exponent",
              int'({exp_o, stage_o}), 226);
    endtask

    task automatic t_period();
        int g;
        for (int e = 0; e <= 9; e++) begin
            sync_pulse();
            sync_pulse();
            measure_gap(g);
            check(g == (1 << e), "R2", $sformatf("period at exponent %0d", e), g, 1 << e);
            if (e < 9) for (int k = 0; k < 8; k++) adj(1'b1, 1'b1, "R5");
        end
    endtask

    task automatic t_top();
        adj(1'b1, 1'b1, "R7");
        check(exp_o == 4'd9 && stage_o == 8'hFF, "R7", "saturate at top",
              int'({exp_o, stage_o}), (9 << 8) | 255);
        adj(1'b1, 1'b0, "R7");
        adj(1'b0, 1'b1, "R4");
    endtask

    task automatic t_boundary();
        int g;
        // Raise exponent 2 -> 3 in a pulse cycle: one old period of 4, then 8.
        sync_pulse();
        adj(1'b1, 1'b1, "R9");
        measure_gap(g);
        check(g + 1 == 4, "R9", "old period after raise", g + 1, 4);
        measure_gap(g);
        check(g == 8, "R9", "new period after raise", g, 8);
        // Lower exponent 3 -> 2 in a pulse cycle: one old period of 8, then 4.
        sync_pulse();
        adj(1'b0, 1'b1, "R9");
        measure_gap(g);
        check(g + 1 == 8, "R9", "old period after lower", g + 1, 8);
        measure_gap(g);
        check(g == 4, "R9", "new period after lower", g, 4);
    endtask

    task automatic t_bottom();
        for (int i = 0; i < 7; i++) adj(1'b0, 1'b1, "R6");
        adj(1'b0, 1'b0, "R8");
        check(exp_o == 4'd0 && stage_o == 8'd0, "R8", "fine underflow at bottom",
              int'({exp_o, stage_o}), 0);
        adj(1'b0, 1'b1, "R8");
        check(exp_o == 4'd0 && stage_o == 8'd0, "R8", "coarse underflow at bottom",
              int'({exp_o, stage_o}), 0);
        @(negedge clk);
        check(div_tick == 1'b1, "R8", "undivided at bottom", int'(div_tick), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_fine();
        t_coarse();
        t_carry();
        t_borrow();
        t_period();
        t_top();
        for (int i = 0; i < 56; i++) adj(1'b0, 1'b1, "R6");
        adj(1'b1, 1'b0, "R3");
        t_boundary();
        for (int i = 0; i < 16; i++) adj(1'b0, 1'b1, "R6");
        t_bottom();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule